// File: doc/BRIEF.md
# Half-Beat Packing Clock-Domain Transfer

This block takes data beats of half the final width in a fast source clock domain and pairs them into one full word. The earlier beat of a pair becomes the low half of the word and the later beat becomes the high half. Each completed word is passed to a destination clock domain with no phase or frequency relation to the source clock. The handover uses a level-toggle request and a level-toggle acknowledge. Each of these two signals is resynchronized in the domain that receives it.

The source offers beats with a valid/ready handshake. Once a word's second beat is taken, ready drops and stays low until the acknowledge for that word has come back, so only one word is ever in flight. In the destination domain, the new word appears on the output register together with a valid strobe one cycle long. The output register then holds that word until the next transfer. Each domain has its own active-low asynchronous reset.

Top module: `pack_xfer_top`

## Requirements
- R1: A delivered word carries the second beat of its pair in bits [2*HALF_W-1:HALF_W] and the first beat in bits [HALF_W-1:0].
- R2: The first beat taken after reset, and the first beat taken after a word completes, goes into the low half.
- R3: A beat is taken only on a source clock edge where beat_valid_i and beat_ready_o are both high. After a low-half beat is taken, beat_ready_o stays high. Cycles with beat_valid_i low do not advance the pairing.
- R4: In the source cycle after a word's second beat is taken, beat_ready_o is low. Beats offered while beat_ready_o is low are not taken and do not reach any word.
- R5: word_valid_o is high for exactly one destination clock cycle per word.
- R6: word_data_o changes only together with the rising of word_valid_o, and keeps its value between transfers.
- R7: word_valid_o rises between SYNC_STAGES and SYNC_STAGES+2 destination rising edges after the source edge that took the second beat, with SYNC_STAGES=2 by default.
- R8: beat_ready_o returns high after the acknowledge comes back, and a following word transfers correctly.
- R9: While in reset and right after reset, beat_ready_o is 1, word_valid_o is 0 and word_data_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| beat_valid_i | input | 1 | Beat offered |
| beat_data_i | input | HALF_W | Half-width beat |
| beat_ready_o | output | 1 | Beat can be taken; low while a word is in flight |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| word_data_o | output | 2*HALF_W | Last delivered word |

## Verification
Ready falls in the source cycle right after a word's second beat is taken, so the bench samples beat_ready_o at the next source falling edge. The destination strobe cannot be placed exactly in time because the two clocks are unrelated. The bench therefore counts destination rising edges from the source edge that took the second beat, and accepts the strobe anywhere in the window SYNC_STAGES to SYNC_STAGES+2. After the strobe, the bench samples word_valid_o one destination cycle later to confirm it has dropped, and checks that the data stays unchanged over many more cycles. The return of ready depends on a full handshake round trip, so the bench allows it a bounded wait rather than a fixed cycle.

// File: rtl/pack_xfer_pkg.sv
package pack_xfer_pkg;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_sel_e;
endpackage

// File: rtl/pack_xfer_sync.sv
module pack_xfer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) s_q <= '0;
        else         s_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/pack_xfer_src.sv
module pack_xfer_src
  import pack_xfer_pkg::*;
#(
  parameter int HALF_W = 66,
  localparam int WordW = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic [HALF_W-1:0] beat_data_i,
  output logic              beat_ready_o,
  input  logic              ack_sync_i,
  output logic              req_o,
  output logic [WordW-1:0]  word_o
);
  half_sel_e         phase_q;
  logic              busy_q, req_q;
  logic [HALF_W-1:0] lo_q;
  logic [WordW-1:0]  word_q;
  logic              take;

  assign take = beat_valid_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= HALF_LO;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      lo_q    <= '0;
      word_q  <= '0;
    end else if (take) begin
      if (phase_q == HALF_LO) begin
        lo_q    <= beat_data_i;
        phase_q <= HALF_HI;
      end else begin
        word_q  <= {beat_data_i, lo_q};
        phase_q <= HALF_LO;
        req_q   <= ~req_q;  // toggle, not pulse
        busy_q  <= 1'b1;
      end
    end else if (busy_q && (ack_sync_i == req_q)) begin
      busy_q <= 1'b0;
    end
  end

  assign beat_ready_o = ~busy_q;
  assign req_o        = req_q;
  assign word_o       = word_q;
endmodule

// File: rtl/pack_xfer_dst.sv
module pack_xfer_dst #(
  parameter int WORD_W = 132
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_sync_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ack_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  logic req_prev_q, ack_q, valid_q;
  logic [WORD_W-1:0] data_q;
  logic edge_seen;

  assign edge_seen = req_sync_i ^ req_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_prev_q <= 1'b0;
      ack_q      <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      req_prev_q <= req_sync_i;
      valid_q    <= edge_seen;
      if (edge_seen) begin
        data_q <= word_i;  // source holds word until ack returns
        ack_q  <= ~ack_q;
      end
    end
  end

  assign ack_o   = ack_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/pack_xfer_top.sv
module pack_xfer_top #(
  parameter int HALF_W      = 66,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  src_clk_i,
  input  logic                  src_rst_ni,
  input  logic                  beat_valid_i,
  input  logic [HALF_W-1:0]     beat_data_i,
  output logic                  beat_ready_o,
  input  logic                  dst_clk_i,
  input  logic                  dst_rst_ni,
  output logic                  word_valid_o,
  output logic [2*HALF_W-1:0]   word_data_o
);
  localparam int WordW = 2 * HALF_W;

  logic             req, req_sync, ack, ack_sync;
  logic [WordW-1:0] held_word;

  pack_xfer_src #(.HALF_W(HALF_W)) u_src (
    .clk_i       (src_clk_i),
    .rst_ni      (src_rst_ni),
    .beat_valid_i(beat_valid_i),
    .beat_data_i (beat_data_i),
    .beat_ready_o(beat_ready_o),
    .ack_sync_i  (ack_sync),
    .req_o       (req),
    .word_o      (held_word)
  );

  pack_xfer_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (dst_clk_i),
    .rst_ni(dst_rst_ni),
    .d_i   (req),
    .q_o   (req_sync)
  );

  pack_xfer_dst #(.WORD_W(WordW)) u_dst (
    .clk_i     (dst_clk_i),
    .rst_ni    (dst_rst_ni),
    .req_sync_i(req_sync),
    .word_i    (held_word),
    .ack_o     (ack),
    .valid_o   (word_valid_o),
    .data_o    (word_data_o)
  );

  pack_xfer_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (src_clk_i),
    .rst_ni(src_rst_ni),
    .d_i   (ack),
    .q_o   (ack_sync)
  );
endmodule

// File: rtl/pack_xfer_chk.sv
module pack_xfer_chk #(
  parameter int HALF_W = 66
) (
  input logic                src_clk_i,
  input logic                src_rst_ni,
  input logic                beat_valid_i,
  input logic                beat_ready_o,
  input logic                dst_clk_i,
  input logic                dst_rst_ni,
  input logic                word_valid_o,
  input logic [2*HALF_W-1:0] word_data_o
);
  logic par_q, take;
  assign take = beat_valid_i & beat_ready_o;

  always_ff @(posedge src_clk_i or negedge src_rst_ni)
    if (!src_rst_ni) par_q <= 1'b0;
    else if (take)   par_q <= ~par_q;

  p_ready_after_lo_r3: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (take && !par_q) |=> beat_ready_o);

  p_ready_drop_r4: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (take && par_q) |=> !beat_ready_o);

  p_one_cycle_strobe_r5: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    word_valid_o |=> !word_valid_o);

  p_data_hold_r6: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    !word_valid_o |-> $stable(word_data_o));

  always_comb
    if (!dst_rst_ni) begin
      a_reset_out_r9: assert (!word_valid_o);
    end
endmodule

bind pack_xfer_top pack_xfer_chk #(.HALF_W(HALF_W)) u_chk (
  .src_clk_i   (src_clk_i),
  .src_rst_ni  (src_rst_ni),
  .beat_valid_i(beat_valid_i),
  .beat_ready_o(beat_ready_o),
  .dst_clk_i   (dst_clk_i),
  .dst_rst_ni  (dst_rst_ni),
  .word_valid_o(word_valid_o),
  .word_data_o (word_data_o)
);

// File: tb/pack_xfer_top_test.sv
module pack_xfer_top_test;
  localparam int HW = 66;
  localparam int WW = 2 * HW;
  localparam int SYNC = 2;

  logic          src_clk = 0, dst_clk = 0;
  logic          src_rst_n = 0, dst_rst_n = 0;
  logic          beat_valid = 0;
  logic [HW-1:0] beat_data = '0;
  logic          beat_ready, word_valid;
  logic [WW-1:0] word_data;

  int checks = 0, errors = 0;

  pack_xfer_top #(.HALF_W(HW), .SYNC_STAGES(SYNC)) uut (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n),
    .beat_valid_i(beat_valid), .beat_data_i(beat_data), .beat_ready_o(beat_ready),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n),
    .word_valid_o(word_valid), .word_data_o(word_data)
  );

  always #10 src_clk = ~src_clk;   // 50 MHz
  always #23 dst_clk = ~dst_clk;

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // offers a beat until taken; returns after the taking edge
  task automatic put_beat(input logic [HW-1:0] d);
    @(negedge src_clk);
    beat_valid = 1'b1;
    beat_data  = d;
    while (!beat_ready) @(negedge src_clk);
    @(posedge src_clk);
    #1 beat_valid = 1'b0;
  endtask

  // sends a pair and checks delivery, latency, strobe width, ready
  task automatic send_pair(input logic [HW-1:0] lo, input logic [HW-1:0] hi,
                           input int gap);
    int n;
    put_beat(lo);
    @(negedge src_clk);
    check(beat_ready == 1'b1, "R3 ready after low beat", WW'(beat_ready), WW'(1));
    repeat (gap) @(negedge src_clk);
    put_beat(hi);
    n = 0;
    fork
      begin
        @(negedge src_clk);
        check(beat_ready == 1'b0, "R4 ready low after word", WW'(beat_ready), WW'(0));
      end
      begin
        while (n < 50) begin
          @(posedge dst_clk); n++;
          @(negedge dst_clk);
          if (word_valid) break;
        end
      end
    join
    check(n >= SYNC && n <= SYNC + 2, "R7 strobe latency", WW'(n), WW'(SYNC + 1));
    check(word_data == {hi, lo}, "R1 R2 word packing", word_data, {hi, lo});
    @(negedge dst_clk);
    check(word_valid == 1'b0, "R5 strobe one cycle", WW'(word_valid), WW'(0));
    n = 0;
    while (!beat_ready && n < 60) begin @(negedge src_clk); n++; end
    check(beat_ready == 1'b1, "R8 ready returns", WW'(beat_ready), WW'(1));
  endtask

  task automatic t_reset();
    #5;
    check(beat_ready == 1'b1, "R9 ready in reset", WW'(beat_ready), WW'(1));
    check(word_valid == 1'b0, "R9 valid in reset", WW'(word_valid), WW'(0));
    check(word_data == '0, "R9 data in reset", word_data, '0);
    repeat (3) @(negedge src_clk);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    repeat (3) @(negedge dst_clk);
    check(word_valid == 1'b0 && word_data == '0, "R9 quiet after reset",
          word_data, '0);
  endtask

  task automatic t_basic();
    send_pair(66'h2_1111_2222_3333_4444, 66'h1_aaaa_bbbb_cccc_dddd, 0);
    send_pair('0, '1, 0);
    send_pair('1, '0, 3);
  endtask

  task automatic t_idle_gap();
    // valid low for many cycles between beats must not advance pairing
    send_pair(66'h0_5555_5555_5555_5555, 66'h3_aaaa_aaaa_aaaa_aaaa, 9);
  endtask

  task automatic t_blocked();
    logic [HW-1:0] lo, hi;
    lo = 66'h1_0f0f_0f0f_0f0f_0f0f;
    hi = 66'h2_f0f0_f0f0_f0f0_f0f0;
    put_beat(lo);
    put_beat(hi);
    // junk offered while ready low
    @(negedge src_clk);
    beat_valid = 1'b1;
    beat_data  = 66'h3_dead_dead_dead_dead;
    repeat (3) @(negedge src_clk);
    check(beat_ready == 1'b0, "R4 still blocked", WW'(beat_ready), WW'(0));
    beat_valid = 1'b0;
    while (!word_valid) @(negedge dst_clk);
    check(word_data == {hi, lo}, "R4 blocked word intact", word_data, {hi, lo});
    while (!beat_ready) @(negedge src_clk);
    send_pair(66'h0_1234_5678_9abc_def0, 66'h1_0fed_cba9_8765_4321, 1);
  endtask

  task automatic t_hold();
    logic [WW-1:0] last;
    int bad;
    last = word_data;
    bad = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge dst_clk);
      if (word_valid || word_data != last) bad++;
    end
    check(bad == 0, "R6 data held while idle", word_data, last);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_idle_gap();
    t_hold();
    t_blocked();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule